// File: doc/BRIEF.md
# Single-Chunk Flash Transfer DMA Engine

This engine copies one chunk of 32-bit words between system memory and the data buffer of a flash controller. The host programs a memory base address, a flash-side base address, a byte length and a direction through a small register port. It then writes the command register. The engine issues one memory beat at a time and steps both addresses by four bytes per word. At the end of the chunk it raises a done flag and a level interrupt.

Longer transfers are driven by the host, one chunk per command. After each chunk the host clears the done flag, advances both addresses by the chunk size and writes the command again. A sticky bus-error flag reports an error response from memory. A stop register aborts a transfer at any point.

The memory port is a request/response pair. A request is offered with `mem_req_valid` and is accepted on a clock edge where `mem_req_ready` is also high. Until that edge the request fields stay unchanged, with one exception: a stop write withdraws the request. Only one beat is outstanding at a time. Each accepted request receives exactly one `mem_rsp_valid` pulse, which acknowledges a write or returns read data, and `mem_rsp_err` flags an error in that pulse. The flash buffer port is a plain word port: `fl_rdata` is read combinationally at `fl_addr`, and `fl_we` writes on the clock edge.

Top module: `chunk_xfer_dma`

## Requirements
- R1: After reset every register reads zero, `irq` is low and `mem_req_valid` is low.
- R2: Writing CMD (offset 0x10) while idle starts a chunk. With bit 0 = 1, word i is read from flash address FADDR+4i and written to memory address MADDR+4i. With bit 0 = 0, word i is read from MADDR+4i and written to FADDR+4i. Data and words outside the chunk are left unchanged.
- R3: The number of words equals LEN divided by 4, rounded down, and is capped at CHUNK_BYTES/4. A count of zero sets DONE in the cycle after the command, and no memory request is issued.
- R4: STATUS (offset 0x18) bit 0 reads 1 from the cycle after a command with a nonzero word count. It reads 0 once the last response has been taken.
- R5: A clean chunk completion sets DONE (offset 0x1C) to 1. A write of value 0 to DONE clears it. A write of any nonzero value to DONE is ignored.
- R6: An error response ends the chunk and no further request is issued. DONE becomes 3 and ERR (offset 0x20) bit 0 becomes 1. The word of the failing read beat is not written to flash. ERR bit 0 keeps its value until a write of 0 to ERR; nonzero writes are ignored.
- R7: CONFIG (offset 0x00) bit 1 reverses the byte order inside each word, in both directions. Bit 0 (NAND mode) and bit 2 (interrupt on error) read back as written. Bit 0 has no effect on the data.
- R8: A write of any value to STOP (offset 0x14) returns the engine to idle in the next cycle. No further requests follow and DONE is not set.
- R9: A CMD write while STATUS bit 0 is 1 is ignored. The running chunk keeps its direction, and CMD reads back its earlier value.
- R10: `irq` is high exactly while DONE is nonzero, or while ERR bit 0 and CONFIG bit 2 are both 1.
- R11: A pending memory request keeps its valid, address and write fields until accepted. The count of accepted requests equals the word count of a clean chunk, or the failing beat index plus one after an error.
- R12: MADDR (offset 0x04), FADDR (offset 0x08) and LEN (offset 0x0C) read back the values written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req_valid | output | 1 | Memory request offered |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 = write beat, 0 = read beat |
| mem_req_addr | output | ADDR_W | Memory byte address |
| mem_req_wdata | output | 32 | Memory write data |
| mem_rsp_valid | input | 1 | Response pulse for the outstanding beat |
| mem_rsp_rdata | input | 32 | Read data |
| mem_rsp_err | input | 1 | Error response |
| fl_addr | output | ADDR_W | Flash buffer byte address |
| fl_we | output | 1 | Flash buffer write strobe |
| fl_wdata | output | 32 | Flash buffer write data |
| fl_rdata | input | 32 | Flash buffer read data at fl_addr |
| irq | output | 1 | Level interrupt |

## Verification
The hardest situations to reach are a bus error in the middle of a chunk and a stop that lands while a request is waiting for acceptance. The memory model in the bench therefore has a programmable index for the failing beat. It also throttles `mem_req_ready` and varies response latency with a shift register, so stalled requests occur often. The stop is written a few cycles after a full-size command, while the engine is still mid-chunk. The bench then confirms that no further requests appear and that DONE stays clear.

// File: rtl/xdma_pkg.sv
package xdma_pkg;
  localparam logic [5:0] OFS_CFG   = 6'h00;
  localparam logic [5:0] OFS_MADDR = 6'h04;
  localparam logic [5:0] OFS_FADDR = 6'h08;
  localparam logic [5:0] OFS_LEN   = 6'h0C;
  localparam logic [5:0] OFS_CMD   = 6'h10;
  localparam logic [5:0] OFS_STOP  = 6'h14;
  localparam logic [5:0] OFS_STAT  = 6'h18;
  localparam logic [5:0] OFS_DONE  = 6'h1C;
  localparam logic [5:0] OFS_ERR   = 6'h20;

  typedef enum logic [1:0] {SQ_IDLE, SQ_REQ, SQ_RESP} sq_state_e;

  typedef struct packed {
    logic irq_err_en;
    logic swap;
    logic nand_mode;
  } cfg_t;
endpackage

// File: rtl/xdma_bswap.sv
module xdma_bswap #(
  parameter int BYTES = 4
) (
  input  logic               en,
  input  logic [8*BYTES-1:0] din,
  output logic [8*BYTES-1:0] dout
);
  logic [8*BYTES-1:0] swapped;

  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    assign swapped[8*b +: 8] = din[8*(BYTES-1-b) +: 8];
  end

  assign dout = en ? swapped : din;
endmodule

// File: rtl/xdma_regs.sv
module xdma_regs
  import xdma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [5:0]        addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              busy,
  input  logic              fin_ok,
  input  logic              fin_err,
  output cfg_t              cfg,
  output logic [ADDR_W-1:0] maddr,
  output logic [ADDR_W-1:0] faddr,
  output logic [LEN_W-1:0]  len,
  output logic              dir,
  output logic              start,
  output logic              stop,
  output logic [1:0]        done,
  output logic              err
);
  logic wr_zero;

  assign start   = we && (addr == OFS_CMD) && !busy;
  assign stop    = we && (addr == OFS_STOP);
  assign wr_zero = (wdata == 32'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg   <= '0;
      maddr <= '0;
      faddr <= '0;
      len   <= '0;
      dir   <= 1'b0;
      done  <= 2'b00;
      err   <= 1'b0;
    end else begin
      if (we && addr == OFS_CFG)   cfg   <= cfg_t'(wdata[2:0]);
      if (we && addr == OFS_MADDR) maddr <= wdata[ADDR_W-1:0];
      if (we && addr == OFS_FADDR) faddr <= wdata[ADDR_W-1:0];
      if (we && addr == OFS_LEN)   len   <= wdata[LEN_W-1:0];
      if (start)                   dir   <= wdata[0];

      if (fin_err)                                    done <= 2'b11;
      else if (fin_ok)                                done <= done | 2'b01;
      else if (we && addr == OFS_DONE && wr_zero)     done <= 2'b00;

      if (fin_err)                                    err <= 1'b1;
      else if (we && addr == OFS_ERR && wr_zero)      err <= 1'b0;
    end
  end

  always_comb begin
    case (addr)
      OFS_CFG:   rdata = {29'd0, cfg};
      OFS_MADDR: rdata = 32'(maddr);
      OFS_FADDR: rdata = 32'(faddr);
      OFS_LEN:   rdata = 32'(len);
      OFS_CMD:   rdata = {31'd0, dir};
      OFS_STAT:  rdata = {31'd0, busy};
      OFS_DONE:  rdata = {30'd0, done};
      OFS_ERR:   rdata = {31'd0, err};
      default:   rdata = 32'd0;
    endcase
  end
endmodule

// File: rtl/xdma_seq.sv
module xdma_seq
  import xdma_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int LEN_W       = 10,
  parameter int CHUNK_WORDS = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              stop,
  input  logic              dir,
  input  logic [ADDR_W-1:0] maddr,
  input  logic [ADDR_W-1:0] faddr,
  input  logic [LEN_W-1:0]  len,
  input  logic              swap,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_write,
  output logic [ADDR_W-1:0] req_addr,
  output logic [31:0]       req_wdata,
  input  logic              rsp_valid,
  input  logic [31:0]       rsp_rdata,
  input  logic              rsp_err,
  output logic [ADDR_W-1:0] fl_addr,
  output logic              fl_we,
  output logic [31:0]       fl_wdata,
  input  logic [31:0]       fl_rdata,
  output logic              busy,
  output logic              wait_rsp,
  output logic              fin_ok,
  output logic              fin_err
);
  localparam int CNT_W = $clog2(CHUNK_WORDS + 1);

  sq_state_e         state;
  logic [CNT_W-1:0]  idx, nbeats, n_req;
  logic [ADDR_W-1:0] mbase, fbase, offs;
  logic [LEN_W-1:0]  words;
  logic              last, rsp_take;

  assign words    = len >> 2;
  assign n_req    = (32'(words) > CHUNK_WORDS) ? CNT_W'(CHUNK_WORDS) : CNT_W'(words);
  assign offs     = ADDR_W'({idx, 2'b00});
  assign last     = (idx + CNT_W'(1)) == nbeats;
  assign busy     = (state != SQ_IDLE);
  assign wait_rsp = (state == SQ_RESP);
  assign rsp_take = wait_rsp && rsp_valid && !stop;

  assign req_valid = (state == SQ_REQ);
  assign req_write = dir;
  assign req_addr  = mbase + offs;
  assign fl_addr   = fbase + offs;
  assign fl_we     = rsp_take && !rsp_err && !dir;
  assign fin_err   = rsp_take && rsp_err;
  assign fin_ok    = (rsp_take && !rsp_err && last) ||
                     ((state == SQ_IDLE) && start && !stop && n_req == '0);

  xdma_bswap #(.BYTES(4)) u_sw_out (.en(swap), .din(fl_rdata),  .dout(req_wdata));
  xdma_bswap #(.BYTES(4)) u_sw_in  (.en(swap), .din(rsp_rdata), .dout(fl_wdata));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= SQ_IDLE;
      idx    <= '0;
      nbeats <= '0;
      mbase  <= '0;
      fbase  <= '0;
    end else if (stop) begin
      state <= SQ_IDLE;
    end else begin
      case (state)
        SQ_IDLE: if (start) begin
          idx    <= '0;
          nbeats <= n_req;
          mbase  <= maddr;
          fbase  <= faddr;
          state  <= (n_req == '0) ? SQ_IDLE : SQ_REQ;
        end
        SQ_REQ: if (req_ready) state <= SQ_RESP;
        SQ_RESP: if (rsp_valid) begin
          if (rsp_err || last) begin
            state <= SQ_IDLE;
          end else begin
            idx   <= idx + CNT_W'(1);
            state <= SQ_REQ;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/chunk_xfer_dma.sv
module chunk_xfer_dma
  import xdma_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int CHUNK_BYTES = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [5:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [31:0]       mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_rdata,
  input  logic              mem_rsp_err,
  output logic [ADDR_W-1:0] fl_addr,
  output logic              fl_we,
  output logic [31:0]       fl_wdata,
  input  logic [31:0]       fl_rdata,
  output logic              irq
);
  localparam int CHUNK_WORDS = CHUNK_BYTES / 4;
  localparam int LEN_W       = $clog2(CHUNK_BYTES) + 1;

  cfg_t              cfg;
  logic [ADDR_W-1:0] maddr, faddr;
  logic [LEN_W-1:0]  len;
  logic              dir_q, start, stop, busy, wait_rsp, fin_ok, fin_err, err_q;
  logic [1:0]        done_q;

  xdma_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .busy(busy), .fin_ok(fin_ok), .fin_err(fin_err),
    .cfg(cfg), .maddr(maddr), .faddr(faddr), .len(len), .dir(dir_q),
    .start(start), .stop(stop), .done(done_q), .err(err_q)
  );

  xdma_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .CHUNK_WORDS(CHUNK_WORDS)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .dir(dir_q),
    .maddr(maddr), .faddr(faddr), .len(len), .swap(cfg.swap),
    .req_valid(mem_req_valid), .req_ready(mem_req_ready), .req_write(mem_req_write),
    .req_addr(mem_req_addr), .req_wdata(mem_req_wdata),
    .rsp_valid(mem_rsp_valid), .rsp_rdata(mem_rsp_rdata), .rsp_err(mem_rsp_err),
    .fl_addr(fl_addr), .fl_we(fl_we), .fl_wdata(fl_wdata), .fl_rdata(fl_rdata),
    .busy(busy), .wait_rsp(wait_rsp), .fin_ok(fin_ok), .fin_err(fin_err)
  );

  assign irq = (done_q != 2'b00) || (err_q && cfg.irq_err_en);
endmodule

// File: rtl/xdma_chk.sv
module xdma_chk
  import xdma_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [5:0]        reg_addr,
  input logic [31:0]       reg_wdata,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_write,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              mem_rsp_valid,
  input logic              mem_rsp_err,
  input logic              busy,
  input logic              wait_rsp,
  input logic [1:0]        done_q,
  input logic              err_q,
  input logic              dir_q
);
  logic stop_w, err_clr_w;
  assign stop_w    = reg_we && reg_addr == OFS_STOP;
  assign err_clr_w = reg_we && reg_addr == OFS_ERR && reg_wdata == 32'd0;

  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready && !stop_w |=>
      mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write));

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req_valid);

  p_stop_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_w |=> !busy && !mem_req_valid);

  p_err_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wait_rsp && mem_rsp_valid && mem_rsp_err && !stop_w |=>
      done_q == 2'b11 && err_q && !busy);

  p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err_q && !err_clr_w |=> err_q);

  p_cmd_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && reg_we && reg_addr == OFS_CMD |=> $stable(dir_q));
endmodule

bind chunk_xfer_dma xdma_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
  .mem_rsp_valid(mem_rsp_valid), .mem_rsp_err(mem_rsp_err),
  .busy(busy), .wait_rsp(wait_rsp), .done_q(done_q), .err_q(err_q), .dir_q(dir_q)
);

// File: tb/sim_chunk_xfer_dma.sv
`timescale 1ns/1ps
module sim_chunk_xfer_dma;
  import xdma_pkg::*;
  localparam int CB = 64;
  localparam int CW = CB / 4;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        mem_req_valid, mem_req_write, fl_we, irq;
  logic        mem_req_ready = 1'b0, mem_rsp_valid = 1'b0, mem_rsp_err = 1'b0;
  logic [31:0] mem_req_addr, mem_req_wdata, fl_addr, fl_wdata, fl_rdata;
  logic [31:0] mem_rsp_rdata = '0;

  chunk_xfer_dma #(.ADDR_W(32), .CHUNK_BYTES(CB)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_rdata(mem_rsp_rdata), .mem_rsp_err(mem_rsp_err),
    .fl_addr(fl_addr), .fl_we(fl_we), .fl_wdata(fl_wdata), .fl_rdata(fl_rdata),
    .irq(irq)
  );

  always #10 clk = ~clk;

  logic [31:0] mem  [0:63];
  logic [31:0] fbuf [0:15];
  int n_run = 0, n_fail = 0;
  bit ended = 0;
  int err_at = -1, fill_req = 0, fill_seed = 0;
  int fill_ack = 0, beat_no = 0, req_cnt = 0, pend = 0;
  logic [5:0]  pa = '0;
  logic [31:0] pw = '0;
  logic        pwr = 1'b0;
  logic [7:0]  lfsr = 8'h5B;

  assign fl_rdata = fbuf[fl_addr[5:2]];

  // Memory and flash buffer model, single owner of both arrays.
  always @(posedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_req_ready <= lfsr[0] | lfsr[2];
    mem_rsp_valid <= 1'b0;
    if (fill_req != fill_ack) begin
      for (int i = 0; i < 64; i++)
        mem[i] = {8'(fill_seed), 8'(i), 8'(~i), 8'(i * 7 + fill_seed)};
      for (int i = 0; i < 16; i++)
        fbuf[i] = {8'hF0 ^ 8'(fill_seed), 8'(i + 64), 8'(i * 13), 8'(fill_seed + i)};
      beat_no  = 0;
      req_cnt  = 0;
      fill_ack = fill_req;
    end else begin
      if (fl_we) fbuf[fl_addr[5:2]] <= fl_wdata;
      if (pend > 0) begin
        pend = pend - 1;
        if (pend == 0) begin
          mem_rsp_valid <= 1'b1;
          mem_rsp_err   <= (beat_no == err_at);
          mem_rsp_rdata <= mem[pa];
          if (pwr && beat_no != err_at) mem[pa] <= pw;
          beat_no = beat_no + 1;
        end
      end else if (mem_req_valid && mem_req_ready) begin
        pa      = mem_req_addr[7:2];
        pw      = mem_req_wdata;
        pwr     = mem_req_write;
        pend    = 1 + int'(lfsr[1]) + int'(lfsr[3]);
        req_cnt = req_cnt + 1;
      end
    end
  end

  function automatic logic [31:0] bs(input logic [31:0] x);
    return {x[7:0], x[15:8], x[23:16], x[31:24]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic refill(input int seed);
    fill_seed = seed;
    fill_req++;
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_idle();
    logic [31:0] d;
    for (int t = 0; t < 3000; t++) begin
      @(negedge clk);
      rd(OFS_STAT, d);
      if (d[0] == 1'b0) break;
    end
  endtask

  task automatic run_xfer(input bit dir, input int lenb, input bit sw, input int base,
                          input int errb, input bit dup);
    logic [31:0] em [0:63];
    logic [31:0] ef [0:15];
    logic [31:0] d;
    int eff, bad, expreq;
    string tag;
    err_at = errb;
    refill(lenb * 3 + base + int'(dir) * 17 + int'(sw) * 5);
    em = mem;
    ef = fbuf;
    eff = lenb / 4;
    if (eff > CW) eff = CW;
    for (int i = 0; i < eff; i++) begin
      if (errb >= 0 && i >= errb) break;
      if (dir) em[base + i] = sw ? bs(fbuf[i]) : fbuf[i];
      else     ef[i]        = sw ? bs(mem[base + i]) : mem[base + i];
    end
    wr(OFS_CFG, {30'd0, sw, 1'b1});
    wr(OFS_MADDR, 32'(base * 4));
    wr(OFS_FADDR, 32'd0);
    wr(OFS_LEN, 32'(lenb));
    wr(OFS_CMD, {31'd0, dir});
    if (dup) wr(OFS_CMD, {31'd0, ~dir});
    rd(OFS_STAT, d);
    chk(d[0] == (eff != 0), "R4 busy after command", d, 32'(eff != 0));
    wait_idle();
    rd(OFS_DONE, d);
    chk(d == ((errb >= 0) ? 32'd3 : 32'd1), (errb >= 0) ? "R6 done on error" : "R5 done on completion",
        d, (errb >= 0) ? 32'd3 : 32'd1);
    bad = 0;
    for (int i = 0; i < 64; i++) if (mem[i] !== em[i]) bad++;
    for (int i = 0; i < 16; i++) if (fbuf[i] !== ef[i]) bad++;
    tag = sw ? "R7 swapped data" : (dup ? "R9 data with ignored command" : "R2 data movement");
    chk(bad == 0, tag, 32'(bad), 32'd0);
    expreq = (errb >= 0) ? errb + 1 : eff;
    chk(req_cnt == expreq, "R11 R3 request count", 32'(req_cnt), 32'(expreq));
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(OFS_CFG, d);   chk(d == 0, "R1 CONFIG reset", d, 0);
    rd(OFS_MADDR, d); chk(d == 0, "R1 MADDR reset", d, 0);
    rd(OFS_LEN, d);   chk(d == 0, "R1 LEN reset", d, 0);
    rd(OFS_STAT, d);  chk(d == 0, "R1 STATUS reset", d, 0);
    rd(OFS_DONE, d);  chk(d == 0, "R1 DONE reset", d, 0);
    rd(OFS_ERR, d);   chk(d == 0, "R1 ERR reset", d, 0);
    chk(irq == 1'b0, "R1 irq reset", 32'(irq), 0);
    chk(mem_req_valid == 1'b0, "R1 no request", 32'(mem_req_valid), 0);

    // R12 register readback, R7 config bits
    wr(OFS_MADDR, 32'h0000_1234); rd(OFS_MADDR, d); chk(d == 32'h1234, "R12 MADDR", d, 32'h1234);
    wr(OFS_FADDR, 32'h0000_0020); rd(OFS_FADDR, d); chk(d == 32'h20, "R12 FADDR", d, 32'h20);
    wr(OFS_LEN, 32'd45);          rd(OFS_LEN, d);   chk(d == 45, "R12 LEN", d, 45);
    wr(OFS_CFG, 32'd7);           rd(OFS_CFG, d);   chk(d == 7, "R7 CONFIG readback", d, 7);
    wr(OFS_CFG, 32'd0);

    // Sweep: both directions, swap off/on, every word count with ragged byte lengths (R2 R3 R7)
    for (int dr = 0; dr < 2; dr++)
      for (int s = 0; s < 2; s++)
        for (int w = 0; w <= CW; w++) begin
          run_xfer(dr[0], w * 4 + (w % 4), s[0], (w * 3) % 48, -1, 1'b0);
          wr(OFS_DONE, 32'd0);
        end

    // R3 clamp: LEN above the chunk moves exactly one chunk
    run_xfer(1'b1, 127, 1'b0, 40, -1, 1'b0);

    // R5 nonzero write ignored, R10 irq follows DONE
    wr(OFS_DONE, 32'd2);
    rd(OFS_DONE, d); chk(d == 1, "R5 nonzero DONE write ignored", d, 1);
    chk(irq == 1'b1, "R10 irq with DONE set", 32'(irq), 1);
    wr(OFS_DONE, 32'd0);
    rd(OFS_DONE, d); chk(d == 0, "R5 DONE cleared", d, 0);
    chk(irq == 1'b0, "R10 irq low after clear", 32'(irq), 0);

    // R9 command while busy
    run_xfer(1'b1, 64, 1'b0, 8, -1, 1'b1);
    rd(OFS_CMD, d); chk(d == 1, "R9 CMD unchanged", d, 1);
    wr(OFS_DONE, 32'd0);

    // R6 bus error at beat 3 of a memory-to-flash chunk
    run_xfer(1'b0, 32, 1'b0, 4, 3, 1'b0);
    rd(OFS_ERR, d); chk(d == 1, "R6 ERR set", d, 1);
    repeat (10) @(negedge clk);
    chk(mem_req_valid == 1'b0, "R6 no beats after error", 32'(mem_req_valid), 0);
    chk(req_cnt == 4, "R6 request count after error", 32'(req_cnt), 4);
    wr(OFS_CFG, 32'd1);
    wr(OFS_DONE, 32'd0);
    chk(irq == 1'b0, "R10 irq off with error enable clear", 32'(irq), 0);
    wr(OFS_ERR, 32'd5);
    rd(OFS_ERR, d); chk(d == 1, "R6 ERR sticky on nonzero write", d, 1);
    wr(OFS_CFG, 32'd4);
    chk(irq == 1'b1, "R10 irq from error with enable", 32'(irq), 1);
    wr(OFS_ERR, 32'd0);
    rd(OFS_ERR, d); chk(d == 0, "R6 ERR cleared", d, 0);
    chk(irq == 1'b0, "R10 irq low after ERR clear", 32'(irq), 0);
    wr(OFS_CFG, 32'd0);
    err_at = -1;

    // R8 stop in the middle of a full chunk
    refill(99);
    wr(OFS_MADDR, 32'd0);
    wr(OFS_LEN, 32'd64);
    wr(OFS_CMD, 32'd1);
    repeat (3) @(negedge clk);
    wr(OFS_STOP, 32'd7);
    rd(OFS_STAT, d); chk(d == 0, "R8 idle after stop", d, 0);
    repeat (20) @(negedge clk);
    rd(OFS_DONE, d); chk(d == 0, "R8 no DONE after stop", d, 0);
    chk(irq == 1'b0, "R8 irq low after stop", 32'(irq), 0);
    chk(mem_req_valid == 1'b0, "R8 no request after stop", 32'(mem_req_valid), 0);

    // engine usable again after stop
    run_xfer(1'b0, 20, 1'b1, 10, -1, 1'b0);
    wr(OFS_DONE, 32'd0);

    ended = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule